// File: doc/BRIEF.md
# Twenty-bit effective address generator

This block forms the 20-bit effective address of a memory operand for a 16-bit processor with banked 20-bit addressing. It takes a mode code and an index select. It also takes the three 20-bit index registers X, Y and Z, the 16-bit accumulator E, the instruction address, a 4-bit bank extension and the operand field that follows the opcode. From these it produces the address in the same cycle.

All offset arithmetic runs across the full 20 bits. A carry or borrow out of the low 16 bits therefore moves the address into the next or previous 64 KB bank without extra handling. The post-modify mode uses X unchanged as the address and presents an updated X one clock later. The block also splits a multiply-accumulate offset byte into two signed 4-bit offsets, one for each index register involved.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode codes are 0 EXT, 1 EXT20, 2 IMM8, 3 IMM16, 4 IND8, 5 IND16, 6 IND20, 7 EOFF, 8 IXP, 9 REL8 and 10 REL16. EXT returns {bank, opnd[15:0]}. EXT20 returns opnd[19:0].
- R2: IMM8 and IMM16 return the address of the operand that follows the opcode, which is pc + OPC_BYTES (default 2).
- R3: IND8 adds opnd[7:0] to the selected index register, zero-extended. idx_sel 0 selects X, 1 selects Y, and 2 or 3 selects Z.
- R4: IND16 adds opnd[15:0], sign-extended, to the selected index register. IND20 adds opnd[19:0].
- R5: EOFF adds accumulator E to the selected index register, with E sign-extended from 16 bits.
- R6: IXP returns X unchanged as ea. On the next clock edge wb_en goes high for exactly one cycle, and wb_val holds X + sign-extended opnd[7:0]. In every other mode, wb_en is low after the edge.
- R7: REL8 and REL16 add sign-extended opnd[7:0] or opnd[15:0] to pc.
- R8: All sums wrap modulo 2^20, so bits 19:16 follow carries and borrows across a bank boundary. The bank input affects only EXT.
- R9: mac_hi is opnd[7:4] sign-extended to 20 bits and mac_lo is opnd[3:0] sign-extended, valid in every mode.
- R10: After reset, wb_en and wb_val are 0. Mode codes 11 to 15 give ea = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 4 | Addressing mode code |
| idx_sel | input | 2 | Index register select |
| x | input | 20 | Index register X |
| y | input | 20 | Index register Y |
| z | input | 20 | Index register Z |
| acc_e | input | 16 | Accumulator E |
| pc | input | 20 | Address of the current instruction |
| bank | input | 4 | Bank extension nibble |
| opnd | input | 20 | Operand field after the opcode |
| ea | output | 20 | Effective address, combinational |
| wb_en | output | 1 | Index X write-back strobe, registered |
| wb_val | output | 20 | Index X write-back value, registered |
| mac_hi | output | 20 | Sign-extended upper offset nibble |
| mac_lo | output | 20 | Sign-extended lower offset nibble |

## Verification
A post-modify write-back and the next instruction's address computation can fall in the same cycle. The registered X update is presented while a new mode is already driving ea. The bench applies IXP and then, right after it, an IND8 access off X. In the overlap cycle it checks that wb_en and wb_val carry the post-modified X and that ea is built from the X input then present, not from the pending write-back. A second IXP right after the first checks that the strobe stays high and carries the new value.

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int AW = 20,
  parameter int OPC_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic [1:0]    idx_sel,
  input  logic [AW-1:0] x,
  input  logic [AW-1:0] y,
  input  logic [AW-1:0] z,
  input  logic [15:0]   acc_e,
  input  logic [AW-1:0] pc,
  input  logic [AW-17:0] bank,
  input  logic [AW-1:0] opnd,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic [AW-1:0] mac_hi,
  output logic [AW-1:0] mac_lo
);
  localparam logic [3:0] M_EXT = 4'd0, M_EXT20 = 4'd1, M_IMM8 = 4'd2, M_IMM16 = 4'd3,
                         M_IND8 = 4'd4, M_IND16 = 4'd5, M_IND20 = 4'd6, M_EOFF = 4'd7,
                         M_IXP = 4'd8, M_REL8 = 4'd9, M_REL16 = 4'd10;

  logic [AW-1:0] base, off8u, off8s, off16s, offe;

  assign base   = (idx_sel == 2'd0) ? x : (idx_sel == 2'd1) ? y : z;
  assign off8u  = {{(AW-8){1'b0}}, opnd[7:0]};
  assign off8s  = {{(AW-8){opnd[7]}}, opnd[7:0]};
  assign off16s = {{(AW-16){opnd[15]}}, opnd[15:0]};
  assign offe   = {{(AW-16){acc_e[15]}}, acc_e};
  assign mac_hi = {{(AW-4){opnd[7]}}, opnd[7:4]};
  assign mac_lo = {{(AW-4){opnd[3]}}, opnd[3:0]};

  always_comb begin
    case (mode)
      M_EXT:           ea = {bank, opnd[15:0]};
      M_EXT20:         ea = opnd;
      M_IMM8, M_IMM16: ea = pc + AW'(OPC_BYTES);
      M_IND8:          ea = base + off8u;
      M_IND16:         ea = base + off16s;
      M_IND20:         ea = base + opnd;
      M_EOFF:          ea = base + offe;
      M_IXP:           ea = x;
      M_REL8:          ea = pc + off8s;
      M_REL16:         ea = pc + off16s;
      default:         ea = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en  <= 1'b0;
      wb_val <= '0;
    end else begin
      wb_en <= (mode == M_IXP);
      if (mode == M_IXP) wb_val <= x + off8s;
    end
  end
endmodule

module eff_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  mode,
  input logic [1:0]  idx_sel,
  input logic [19:0] x,
  input logic [3:0]  bank,
  input logic [19:0] opnd,
  input logic [19:0] ea,
  input logic        wb_en,
  input logic [19:0] mac_hi,
  input logic [19:0] mac_lo
);
  assert_wb_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd8) |=> wb_en);
  assert_wb_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 4'd8) |=> !wb_en);
  assert_ixp_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd8) |-> ea == x);
  assert_ext_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0) |-> (ea[19:16] == bank && ea[15:0] == opnd[15:0]));
  assert_ind8_unsigned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd4 && idx_sel == 2'd0) |-> (20'(ea - x) == {12'b0, opnd[7:0]}));
  assert_mac_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_hi[19:3] == {17{opnd[7]}}) && (mac_lo[19:3] == {17{opnd[3]}}));
  assert_unused_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > 4'd10) |-> ea == 20'h0);
endmodule

bind eff_addr_gen eff_addr_gen_chk chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .idx_sel(idx_sel), .x(x), .bank(bank),
  .opnd(opnd), .ea(ea), .wb_en(wb_en), .mac_hi(mac_hi), .mac_lo(mac_lo));

// File: tb/eff_addr_gen_test.sv
module eff_addr_gen_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] mode = 4'd0;
  logic [1:0] idx_sel = 2'd0;
  logic [19:0] x, y, z, pc, opnd;
  logic [15:0] acc_e;
  logic [3:0] bank;
  logic [19:0] ea, wb_val, mac_hi, mac_lo;
  logic wb_en;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  eff_addr_gen uut (.clk(clk), .rst_n(rst_n), .mode(mode), .idx_sel(idx_sel), .x(x), .y(y),
    .z(z), .acc_e(acc_e), .pc(pc), .bank(bank), .opnd(opnd), .ea(ea), .wb_en(wb_en),
    .wb_val(wb_val), .mac_hi(mac_hi), .mac_lo(mac_lo));

  typedef struct packed {
    logic [3:0]  m;
    logic [1:0]  s;
    logic [19:0] op;
    logic [19:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  2'd0, 20'h01234, 20'h51234},  // R1 EXT
    '{4'd1,  2'd0, 20'hABCDE, 20'hABCDE},  // R1 EXT20
    '{4'd2,  2'd0, 20'h00000, 20'h10000},  // R2 IMM8
    '{4'd3,  2'd0, 20'h00000, 20'h10000},  // R2 IMM16
    '{4'd4,  2'd0, 20'h00080, 20'h20070},  // R3 X, unsigned, bank carry
    '{4'd4,  2'd2, 20'h00010, 20'h0000C},  // R8 Z wraps
    '{4'd4,  2'd3, 20'h00004, 20'h00000},  // R3 sel 3 -> Z
    '{4'd5,  2'd1, 20'h08000, 20'h28008},  // R4 Y minus 0x8000
    '{4'd5,  2'd0, 20'h00020, 20'h20010},  // R4 X
    '{4'd6,  2'd1, 20'hFFFF8, 20'h30000},  // R4 IND20
    '{4'd7,  2'd0, 20'h00000, 20'h1FFEE},  // R5 X + E(-2)
    '{4'd7,  2'd2, 20'h00000, 20'hFFFFA},  // R5 Z + E
    '{4'd8,  2'd1, 20'h000F0, 20'h1FFF0},  // R6 IXP ea = X
    '{4'd9,  2'd0, 20'h00002, 20'h10000},  // R7 REL8 fwd
    '{4'd9,  2'd0, 20'h000FE, 20'h0FFFC},  // R7 REL8 back
    '{4'd10, 2'd0, 20'h08000, 20'h07FFE},  // R7 REL16
    '{4'd12, 2'd0, 20'h12345, 20'h00000}   // R10 unused code
  };

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    x = 20'h1FFF0; y = 20'h30008; z = 20'hFFFFC; acc_e = 16'hFFFE;
    pc = 20'h0FFFE; bank = 4'h5; opnd = '0;
    #5;
    chk("R10 wb_en", {19'b0, wb_en}, 20'h0);
    chk("R10 wb_val", wb_val, 20'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VEC[i].m; idx_sel = VEC[i].s; opnd = VEC[i].op;
      #1 chk($sformatf("vec%0d ea", i), ea, VEC[i].exp);
      @(posedge clk); #1;
      chk($sformatf("R6 vec%0d wb_en", i), {19'b0, wb_en}, {19'b0, VEC[i].m == 4'd8});
      if (VEC[i].m == 4'd8) chk("R6 wb_val", wb_val, 20'h1FFE0);
    end

    // R8: bank ignored outside EXT
    @(negedge clk) mode = 4'd4; idx_sel = 2'd0; opnd = 20'h00080; bank = 4'hA;
    #1 chk("R8 bank ignored", ea, 20'h20070);
    mode = 4'd0; opnd = 20'h0BEEF;
    #1 chk("R1 EXT new bank", ea, 20'hABEEF);

    // R9 MAC split
    opnd = 20'h0007F;
    #1 chk("R9 mac_hi +7", mac_hi, 20'h00007);
    chk("R9 mac_lo -1", mac_lo, 20'hFFFFF);
    opnd = 20'h00081;
    #1 chk("R9 mac_hi -8", mac_hi, 20'hFFFF8);
    chk("R9 mac_lo +1", mac_lo, 20'h00001);

    // R6 overlap: IXP, IXP, then IND8 off a new X while write-back is pending
    @(negedge clk) mode = 4'd8; opnd = 20'h00010; x = 20'h0FFF8;
    @(negedge clk) mode = 4'd8; opnd = 20'h00002; x = 20'h10008;
    #1 chk("R6 back-to-back wb_en", {19'b0, wb_en}, 20'h1);
    chk("R6 back-to-back wb_val", wb_val, 20'h10008);
    chk("R6 back-to-back ea", ea, 20'h10008);
    @(negedge clk) mode = 4'd4; idx_sel = 2'd0; opnd = 20'h00001; x = 20'h20000;
    #1 chk("R6 overlap wb_en", {19'b0, wb_en}, 20'h1);
    chk("R6 overlap wb_val", wb_val, 20'h1000A);
    chk("R3 overlap ea", ea, 20'h20001);
    @(posedge clk); #1;
    chk("R6 pulse ends", {19'b0, wb_en}, 20'h0);
    chk("R6 value held", wb_val, 20'h1000A);

    // R10 reset clears
    rst_n = 1'b0;
    #1 chk("R10 reset wb_val", wb_val, 20'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule